// File: doc/BRIEF.md
# Serial Threefish-512 chaining engine

This block computes one 512-bit unique-block-iteration (UBI) step with 64-bit arithmetic. The step encrypts a message block with Threefish-512, using the current chaining value as the key and two 64-bit tweak words. It then XORs the message back into the result. The result becomes the new chaining value and also the key for the next block. A caller that formats tweaks and padding itself can hash a message by streaming blocks one after another. It then produces the output transform with one more block: an all-zero message with an output-type tweak.

The cipher state lives in two four-word single-port memories, one for the even words and one for the odd words. The word permutation between rounds always maps an even position to an even position and an odd one to an odd one. It is therefore carried out entirely by changing the read and write addresses, and no word is ever moved. A 17-word single-port memory holds three things: the message block (needed for the final XOR), the eight key words and the parity key word. Each subkey word is formed just before it is added, from the tweak registers, the stored keys and the subkey number.

Top module: `threefish_ubi_core`

## Requirements
- R1: While and right after reset, `done` is 0.
- R2: An `iv_go` pulse accepted while idle makes the initial chaining value the eight words 4903ADFF749C51CE, 0D95DE399746DF03, 8FD1934127C79BCE, 9A255629FF352CB1, 5DB62599DF6CA7B0, EABE394CA9D5C3F4, 991112C71A75B523, AE18A40B660FCC33 (hex, word 0 first). `done` rises at the 8th rising edge after the edge that samples `iv_go`, and `rd_word` then shows word i when `rd_addr` = i.
- R3: A `start` pulse accepted while idle processes one block. Message word i (i = 0..7) is taken from `msg_in` at the (i+1)th rising edge after the edge that samples `start`. The result word i, readable on `rd_word` with `rd_addr` = i once `done` is 1, is E[i] XOR M[i]. E is Threefish-512 with 72 rounds, defined as follows.
  - Key: k0..k7 are the chaining words and k8 = 1BD11BDAA9FC1A22 XOR k0..k7.
  - Tweak: t0 = `tweak_lo`, t1 = `tweak_hi`, t2 = t0 XOR t1.
  - Subkeys: subkey s (s = 0..18) word i is k[(s+i) mod 9]. Word 5 adds t[s mod 3], word 6 adds t[(s+1) mod 3] and word 7 adds s.
  - Schedule: subkey s is added before rounds 4s and after round 71.
  - MIX: round d applies MIX to pairs j = 0..3 (words 2j, 2j+1): y0 = x0 + x1 and y1 = rotl(x1, R[d mod 8][j]) XOR y0. The rows of R are 46 36 19 37 / 33 27 14 42 / 17 49 36 39 / 44 9 54 56 / 39 30 34 24 / 13 50 10 17 / 25 29 39 43 / 8 35 56 22.
  - Permutation: after MIX, new word i is old word p(i), with p = 2,1,4,7,6,5,0,3.
- R4: The result of a block is the chaining value used as the key by the next block.
- R5: `done` rises at the 457th rising edge after the edge that samples `start`.
- R6: While a block or an IV load is in progress, `start`, `iv_go` and `msg_in` outside its eight-word window have no effect on the result or the timing.
- R7: When `iv_go` and `start` are both high in an idle cycle, only the IV load is carried out.
- R8: The tweak inputs are sampled only at the edge that accepts `start`. Later changes to them do not alter the block's result.
- R9: `done` is 0 from the edge after `start` or `iv_go` is accepted until the operation completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| iv_go | input | 1 | Load the fixed initial chaining value |
| start | input | 1 | Begin one UBI block |
| tweak_lo | input | 64 | Tweak word t0, sampled with start |
| tweak_hi | input | 64 | Tweak word t1, sampled with start |
| msg_in | input | 64 | Message word stream, one word per cycle after start |
| rd_addr | input | 3 | Result word index |
| rd_word | output | 64 | Chaining value word selected by rd_addr |
| done | output | 1 | Operation complete, result valid |

## Verification
A reference model in the bench computes each block from the key schedule, the MIX function and the permutation. The blocks run are an all-zero message, an all-ones message, and two arithmetic word sequences, all on a chain of results. The zero and all-ones blocks expose errors in the subkey sum and the tweak positions, because the message contributes nothing to mask them. The graded sequences make every word distinct, so a wrong permutation address or a wrong rotation pairing shows up. A run that toggles the control inputs, the tweak and the stray message words mid-block separates input sampling from computation. The combined `iv_go` and `start` case checks priority and confirms that the chaining value returns to the constant.

// File: rtl/threefish_ubi_core.sv
module threefish_ubi_core (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        iv_go,
  input  logic        start,
  input  logic [63:0] tweak_lo,
  input  logic [63:0] tweak_hi,
  input  logic [63:0] msg_in,
  input  logic [2:0]  rd_addr,
  output logic [63:0] rd_word,
  output logic        done
);
  localparam logic [63:0] PARITY_SEED = 64'h1BD11BDAA9FC1A22;
  localparam int          NUM_ROUNDS  = 72;
  localparam int          LAST_SUBKEY = NUM_ROUNDS / 4;

  typedef enum logic [2:0] {S_IDLE, S_IV, S_LOAD, S_INJ, S_RND, S_FF} state_t;

  state_t      st;
  logic [3:0]  cnt;
  logic [6:0]  rnd;
  logic [4:0]  sk;
  logic [3:0]  kix;
  logic [1:0]  tix;
  logic        sel;
  logic [63:0] tw0, tw1, tw2, ext;

  logic [63:0] ev_mem  [4];
  logic [63:0] od_mem  [4];
  logic [63:0] key_mem [17];

  function automatic logic [63:0] iv_word(input logic [2:0] i);
    case (i)
      3'd0: return 64'h4903ADFF749C51CE;
      3'd1: return 64'h0D95DE399746DF03;
      3'd2: return 64'h8FD1934127C79BCE;
      3'd3: return 64'h9A255629FF352CB1;
      3'd4: return 64'h5DB62599DF6CA7B0;
      3'd5: return 64'hEABE394CA9D5C3F4;
      3'd6: return 64'h991112C71A75B523;
      default: return 64'hAE18A40B660FCC33;
    endcase
  endfunction

  function automatic logic [5:0] rot_amt(input logic [4:0] dj);
    case (dj)
      5'd0:  return 6'd46; 5'd1:  return 6'd36; 5'd2:  return 6'd19; 5'd3:  return 6'd37;
      5'd4:  return 6'd33; 5'd5:  return 6'd27; 5'd6:  return 6'd14; 5'd7:  return 6'd42;
      5'd8:  return 6'd17; 5'd9:  return 6'd49; 5'd10: return 6'd36; 5'd11: return 6'd39;
      5'd12: return 6'd44; 5'd13: return 6'd9;  5'd14: return 6'd54; 5'd15: return 6'd56;
      5'd16: return 6'd39; 5'd17: return 6'd30; 5'd18: return 6'd34; 5'd19: return 6'd24;
      5'd20: return 6'd13; 5'd21: return 6'd50; 5'd22: return 6'd10; 5'd23: return 6'd17;
      5'd24: return 6'd25; 5'd25: return 6'd29; 5'd26: return 6'd39; 5'd27: return 6'd43;
      5'd28: return 6'd8;  5'd29: return 6'd35; 5'd30: return 6'd56; default: return 6'd22;
    endcase
  endfunction

  wire idle   = (st == S_IDLE);
  wire in_rnd = (st == S_RND);

  logic [1:0] ev_a, od_a;
  always_comb begin
    if (in_rnd) begin
      ev_a = cnt[1:0] + rnd[1:0];
      od_a = rnd[0] ? 2'd0 - cnt[1:0] : cnt[1:0];
    end else if (idle) begin
      ev_a = rd_addr[2:1];
      od_a = rd_addr[2:1];
    end else begin
      ev_a = cnt[2:1];
      od_a = cnt[2:1];
    end
  end

  wire [63:0] ev_rd = ev_mem[ev_a];
  wire [63:0] od_rd = od_mem[od_a];
  wire [63:0] word  = cnt[0] ? od_rd : ev_rd;
  assign rd_word = rd_addr[0] ? od_rd : ev_rd;
  assign done    = done_q;

  logic done_q;

  wire [3:0] kn     = kix + {1'b0, cnt[2:0]};
  wire [3:0] kw     = (kn >= 4'd9) ? kn - 4'd9 : kn;
  wire [4:0] key_a  = (kw == 4'd8) ? 5'd16 : {1'b0, sel, kw[2:0]};
  wire [4:0] msg_a  = {1'b0, ~sel, cnt[2:0]};
  wire [1:0] tix_n  = (tix == 2'd2) ? 2'd0 : tix + 2'd1;

  logic [4:0]  k_a;
  logic [63:0] k_wd;
  logic        k_we;
  always_comb begin
    k_a  = 5'd0;
    k_wd = 64'd0;
    k_we = 1'b0;
    case (st)
      S_IV:   begin k_a = {1'b0, sel, cnt[2:0]}; k_wd = iv_word(cnt[2:0]); k_we = 1'b1; end
      S_LOAD: begin k_a = cnt[3] ? 5'd16 : msg_a; k_wd = cnt[3] ? ext : msg_in; k_we = 1'b1; end
      S_INJ:  k_a = key_a;
      S_FF:   begin k_a = msg_a; k_wd = word ^ key_rd; k_we = 1'b1; end
      default: ;
    endcase
  end

  logic [63:0] key_rd;
  assign key_rd = key_mem[k_a];

  function automatic logic [63:0] tw_pick(input logic [1:0] i, input logic [63:0] a, b, c);
    return (i == 2'd0) ? a : (i == 2'd1) ? b : c;
  endfunction

  logic [63:0] addend;
  always_comb begin
    case (cnt[2:0])
      3'd5:    addend = tw_pick(tix, tw0, tw1, tw2);
      3'd6:    addend = tw_pick(tix_n, tw0, tw1, tw2);
      3'd7:    addend = {59'd0, sk};
      default: addend = 64'd0;
    endcase
  end

  wire [63:0] inj_w = word + key_rd + addend;
  wire [63:0] ff_w  = word ^ key_rd;
  wire [5:0]  rot   = rot_amt({rnd[2:0], cnt[1:0]});
  wire [63:0] y0    = ev_rd + od_rd;
  wire [63:0] y1    = ((od_rd << rot) | (od_rd >> (7'd64 - {1'b0, rot}))) ^ y0;

  logic [63:0] hw;
  always_comb begin
    case (st)
      S_IV:    hw = iv_word(cnt[2:0]);
      S_LOAD:  hw = msg_in;
      S_INJ:   hw = inj_w;
      default: hw = ff_w;
    endcase
  end

  wire single_we = (st == S_IV) || (st == S_LOAD && !cnt[3]) || (st == S_INJ) || (st == S_FF);
  wire ev_we     = in_rnd || (single_we && !cnt[0]);
  wire od_we     = in_rnd || (single_we && cnt[0]);

  always_ff @(posedge clk) begin
    if (ev_we) ev_mem[ev_a] <= in_rnd ? y0 : hw;
    if (od_we) od_mem[od_a] <= in_rnd ? y1 : hw;
    if (k_we)  key_mem[k_a] <= k_wd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; rnd <= '0; sk <= '0; kix <= '0; tix <= '0;
      sel <= 1'b0; done_q <= 1'b0;
      tw0 <= '0; tw1 <= '0; tw2 <= '0; ext <= '0;
    end else begin
      case (st)
        S_IDLE:
          if (iv_go) begin
            st <= S_IV; cnt <= '0; done_q <= 1'b0;
          end else if (start) begin
            st <= S_LOAD; cnt <= '0; rnd <= '0; sk <= '0; kix <= '0; tix <= '0;
            done_q <= 1'b0;
            tw0 <= tweak_lo; tw1 <= tweak_hi; tw2 <= tweak_lo ^ tweak_hi;
          end
        S_IV: begin
          ext <= ((cnt == 4'd0) ? PARITY_SEED : ext) ^ iv_word(cnt[2:0]);
          cnt <= cnt + 4'd1;
          if (cnt == 4'd7) begin st <= S_IDLE; done_q <= 1'b1; end
        end
        S_LOAD:
          if (cnt == 4'd8) begin cnt <= '0; st <= S_INJ; end
          else cnt <= cnt + 4'd1;
        S_INJ:
          if (cnt == 4'd7) begin
            cnt <= '0;
            if (sk == 5'(LAST_SUBKEY)) st <= S_FF;
            else begin
              st  <= S_RND;
              sk  <= sk + 5'd1;
              kix <= (kix == 4'd8) ? 4'd0 : kix + 4'd1;
              tix <= tix_n;
            end
          end else cnt <= cnt + 4'd1;
        S_RND:
          if (cnt == 4'd3) begin
            cnt <= '0;
            rnd <= rnd + 7'd1;
            if (rnd[1:0] == 2'd3) st <= S_INJ;
          end else cnt <= cnt + 4'd1;
        S_FF: begin
          ext <= ((cnt == 4'd0) ? PARITY_SEED : ext) ^ ff_w;
          if (cnt == 4'd7) begin
            cnt <= '0; st <= S_IDLE; sel <= ~sel; done_q <= 1'b1;
          end else cnt <= cnt + 4'd1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_done_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && (start || iv_go)) |=> !done_q);

  assert_busy_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle) |-> !done_q);

  assert_inj_home_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_INJ) |-> (rnd[1:0] == 2'd0 && kix < 4'd9 && tix < 2'd3));

  assert_sched_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FF) |-> (rnd == 7'(NUM_ROUNDS) && sk == 5'(LAST_SUBKEY)));

  assert_tweak_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle) |=> ($stable(tw0) && $stable(tw1)));

  assert_chain_swap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sel)) |-> $rose(done_q));
endmodule

// File: tb/sim_threefish_ubi_core.sv
module sim_threefish_ubi_core;
  localparam int CLK_PERIOD = 10;

  typedef logic [7:0][63:0] blk_t;

  localparam logic [63:0] C240 = 64'h1BD11BDAA9FC1A22;
  localparam int RC [32] = '{46,36,19,37, 33,27,14,42, 17,49,36,39, 44,9,54,56,
                             39,30,34,24, 13,50,10,17, 25,29,39,43, 8,35,56,22};
  localparam int PERM [8] = '{2,1,4,7,6,5,0,3};
  localparam logic [63:0] IVT [8] = '{64'h4903ADFF749C51CE, 64'h0D95DE399746DF03,
    64'h8FD1934127C79BCE, 64'h9A255629FF352CB1, 64'h5DB62599DF6CA7B0,
    64'hEABE394CA9D5C3F4, 64'h991112C71A75B523, 64'hAE18A40B660FCC33};
  // base, step, tweak_lo, tweak_hi
  localparam logic [255:0] VEC [4] = '{
    {64'h0, 64'h0, 64'h0000000000000040, 64'hF000000000000000},
    {64'hFFFFFFFFFFFFFFFF, 64'h0, 64'h0000000000000008, 64'hFF00000000000000},
    {64'h0123456789ABCDEF, 64'h1111111111111111, 64'h00000000000000C0, 64'h7000000000000000},
    {64'hDEADBEEF00C0FFEE, 64'h9E3779B97F4A7C15, 64'h123456789ABCDEF0, 64'h0FEDCBA987654321}};

  logic clk = 1'b0;
  logic rst_n, iv_go, start;
  logic [63:0] tweak_lo, tweak_hi, msg_in, rd_word;
  logic [2:0] rd_addr;
  logic done;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  threefish_ubi_core u0 (.clk(clk), .rst_n(rst_n), .iv_go(iv_go), .start(start),
    .tweak_lo(tweak_lo), .tweak_hi(tweak_hi), .msg_in(msg_in), .rd_addr(rd_addr),
    .rd_word(rd_word), .done(done));

  function automatic logic [63:0] rotl(input logic [63:0] x, input int n);
    return (x << n) | (x >> (64 - n));
  endfunction

  function automatic blk_t add_sub(input blk_t v, input logic [8:0][63:0] k,
                                   input logic [2:0][63:0] t, input int s);
    blk_t o;
    for (int i = 0; i < 8; i++) begin
      o[i] = v[i] + k[(s + i) % 9];
      if (i == 5) o[i] = o[i] + t[s % 3];
      if (i == 6) o[i] = o[i] + t[(s + 1) % 3];
      if (i == 7) o[i] = o[i] + 64'(s);
    end
    return o;
  endfunction

  function automatic blk_t ubi_ref(input blk_t g, input blk_t m, input logic [63:0] ta, tb);
    logic [8:0][63:0] k;
    logic [2:0][63:0] t;
    blk_t v, f;
    k[8] = C240;
    for (int i = 0; i < 8; i++) begin k[i] = g[i]; k[8] = k[8] ^ g[i]; end
    t[0] = ta; t[1] = tb; t[2] = ta ^ tb;
    v = m;
    for (int r = 0; r < 72; r++) begin
      if (r % 4 == 0) v = add_sub(v, k, t, r / 4);
      for (int j = 0; j < 4; j++) begin
        f[2*j]   = v[2*j] + v[2*j+1];
        f[2*j+1] = rotl(v[2*j+1], RC[(r % 8) * 4 + j]) ^ f[2*j];
      end
      for (int i = 0; i < 8; i++) v[i] = f[PERM[i]];
    end
    v = add_sub(v, k, t, 18);
    return v ^ m;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic read_chk(input blk_t exp, input string tag);
    for (int k = 0; k < 8; k++) begin
      rd_addr = 3'(k);
      #1;
      chk(tag, rd_word, exp[k]);
    end
  endtask

  task automatic run_block(input blk_t m, input logic [63:0] ta, input logic [63:0] tb,
                           input bit disturb, output int ncyc);
    @(negedge clk);
    start = 1'b1; tweak_lo = ta; tweak_hi = tb;
    @(posedge clk);
    ncyc = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (i == 0) chk("R9 done low after start", 64'(done), 64'd0);
      start = 1'b0; msg_in = m[i];
      if (disturb) begin tweak_lo = ~ta; tweak_hi = ta ^ tb ^ 64'h5; end
      @(posedge clk);
      ncyc++;
    end
    while (ncyc < 3000) begin
      @(negedge clk);
      if (disturb) begin
        msg_in = ~msg_in ^ 64'(ncyc);
        start = (ncyc == 100 || ncyc == 300);
        iv_go = (ncyc == 100 || ncyc == 456);
      end
      if (done) break;
      @(posedge clk);
      ncyc++;
    end
    start = 1'b0; iv_go = 1'b0;
  endtask

  task automatic run_iv(input bit with_start, output int ncyc);
    @(negedge clk);
    iv_go = 1'b1; start = with_start;
    @(posedge clk);
    ncyc = 0;
    @(negedge clk);
    iv_go = 1'b0; start = 1'b0;
    while (!done && ncyc < 100) begin
      @(posedge clk);
      ncyc++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    blk_t chain, m, exp, ivb;
    int nc;
    logic [63:0] base, step, ta, tb;
    for (int i = 0; i < 8; i++) ivb[i] = IVT[i];
    rst_n = 1'b0; iv_go = 1'b0; start = 1'b0;
    tweak_lo = '0; tweak_hi = '0; msg_in = '0; rd_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 done in reset", 64'(done), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 done after reset", 64'(done), 64'd0);

    run_iv(1'b0, nc);
    chk("R2 iv load latency", 64'(nc), 64'd8);
    read_chk(ivb, "R2 iv word");
    chain = ivb;

    for (int e = 0; e < 4; e++) begin
      {base, step, ta, tb} = VEC[e];
      for (int i = 0; i < 8; i++) m[i] = base + step * 64'(i);
      exp = ubi_ref(chain, m, ta, tb);
      run_block(m, ta, tb, 1'b0, nc);
      chk("R5 block latency", 64'(nc), 64'd457);
      read_chk(exp, (e == 0) ? "R3 block result" : "R4 chained result");
      chain = exp;
    end

    for (int i = 0; i < 8; i++) m[i] = 64'h0F1E2D3C4B5A6978 * 64'(i + 3);
    ta = 64'hA5A5A5A5_00000080; tb = 64'h3000000000000000;
    exp = ubi_ref(chain, m, ta, tb);
    run_block(m, ta, tb, 1'b1, nc);
    chk("R6 latency with noise", 64'(nc), 64'd457);
    read_chk(exp, "R6 R8 result with noise");
    chain = exp;

    run_iv(1'b1, nc);
    chk("R7 iv priority latency", 64'(nc), 64'd8);
    read_chk(ivb, "R7 iv priority word");
    chain = ivb;
    for (int i = 0; i < 8; i++) m[i] = 64'(i) << (8 * i);
    exp = ubi_ref(chain, m, 64'h20, 64'hC000000000000000);
    run_block(m, 64'h20, 64'hC000000000000000, 1'b0, nc);
    read_chk(exp, "R7 block keyed by iv");

    summary();
    $finish;
  end
endmodule